// File: doc/BRIEF.md
# FPGA Serial Configuration Sequencer

This block loads a configuration bitstream into a slave FPGA that sits on a shared serial clock and data pair. A single start pulse launches it. It raises the program control line and waits for the FPGA to report that it is ready to receive. It then takes bitstream bytes from an upstream source over a ready/valid handshake and clocks them out most significant bit first. When the last byte has gone out, it waits for the FPGA's done status to go high. It then counts out a minimum hold-off in system clocks before it releases the separate active-low user reset of the FPGA.

Each wait has a timeout. If the ready status does not appear within a parameterised number of cycles, the sequencer stops in an error state with a code that says which wait failed. The done status works the same way. In the error state the user reset stays asserted. A new start pulse from the finished or the error state runs the whole sequence again from the beginning.

Top module: `fpga_cfg_seq`

## Requirements
- R1: While reset is applied and right after it, prog_o, ureset_n_o, spi_sck_o, spi_mosi_o, byte_ready_o, busy_o, done_o and err_o are all 0, and err_code_o is 0.
- R2: The clock edge that samples start_i high from the idle state drives prog_o and busy_o to 1. prog_o stays 1 until done_o is reported.
- R3: Before the synchronised ready status input has been seen high, spi_sck_o makes no pulse and byte_ready_o stays 0, however long the wait lasts.
- R4: Every accepted byte is sent as eight spi_sck_o pulses, most significant bit first. spi_mosi_o holds steady across each rising edge of spi_sck_o. Within a byte, consecutive rising edges are 2*CLK_DIV system clocks apart.
- R5: ureset_n_o stays 0 for the whole of the transfer and while the sequencer waits for the done status.
- R6: ureset_n_o rises no sooner than HOLD_CYCLES system clocks after the done status input goes high, and no later than HOLD_CYCLES+SYNC_STAGES+4 clocks after it. It rises together with done_o.
- R7: If the ready status is not seen within RDY_TIMEOUT cycles of start, the sequencer sets err_o with err_code_o = 1, drops prog_o, keeps ureset_n_o at 0 and sends no clock pulses.
- R8: If the done status is not seen within DONE_TIMEOUT cycles of the end of the transfer, the sequencer sets err_o with err_code_o = 2 and keeps ureset_n_o at 0.
- R9: start_i is ignored while busy_o is 1 and the bitstream that goes out is unchanged. start_i from the finished or the error state restarts the sequence, driving ureset_n_o back to 0 and clearing done_o, err_o and err_code_o.
- R10: done_o and err_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that launches a configuration run |
| byte_data_i | input | 8 | Bitstream byte from the upstream source |
| byte_valid_i | input | 1 | Upstream byte is valid |
| byte_last_i | input | 1 | Marks the final byte of the bitstream |
| byte_ready_o | output | 1 | Sequencer accepts a byte this cycle |
| rdy_st_i | input | 1 | FPGA ready-to-receive status (asynchronous) |
| done_st_i | input | 1 | FPGA configuration-done status (asynchronous) |
| prog_o | output | 1 | Program control line to the FPGA |
| spi_sck_o | output | 1 | Shared serial clock |
| spi_mosi_o | output | 1 | Shared serial data output |
| ureset_n_o | output | 1 | Active-low FPGA user reset |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished and user reset released |
| err_o | output | 1 | Run stopped on a timeout |
| err_code_o | output | 2 | 0 none, 1 ready timeout, 2 done timeout |

## Verification
A wrong state register shows at the ports within one clock. prog_o, busy_o, byte_ready_o and ureset_n_o are all decoded from it, so a jump to the wrong phase changes their pattern on the next cycle. A broken shift register or bit counter shows up in the first byte as a changed value or a wrong count of clock pulses, and that byte can be rebuilt from the serial lines. A fault in the hold-off or timeout counter moves the rise of ureset_n_o or err_o by a measurable number of cycles. The sweep runs with a small hold and small timeouts, so each such edge can be checked against an exact window.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WAIT_RDY = 3'd1,
      ST_XFER     = 3'd2,
      ST_CHK_DONE = 3'd3,
      ST_HOLD     = 3'd4,
      ST_FINISH   = 3'd5,
      ST_ERROR    = 3'd6
   } fcs_state_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_RDY_TO  = 2'd1,
      ERR_DONE_TO = 2'd2
   } fcs_err_e;

   function automatic int fcs_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/fcs_sync.sv
// Brings an asynchronous status level into the clock domain.
// STAGES = 0 passes the level straight through.
module fcs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("fcs_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else if (STAGES == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= d_i;
      end
      assign q_o = q;
   end else begin : g_chain
      logic [STAGES-1:0] ch;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ch <= '0;
         else        ch <= {ch[STAGES-2:0], d_i};
      end
      assign q_o = ch[STAGES-1];
   end

endmodule

// File: rtl/fcs_timer.sv
// Down counter that is loaded with a value and stops at zero.
module fcs_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   if (W < 1) begin : g_bad_w
      $error("fcs_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load_i)       cnt <= val_i;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero_o = (cnt == '0);

endmodule

// File: rtl/fcs_shifter.sv
// Serialises one byte at a time, MSB first. The clock idles low and the
// data line changes only on the falling half, so it is steady at each rise.
module fcs_shifter #(
   parameter int CLK_DIV = 2,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              idle_o,
   output logic              sck_o,
   output logic              mosi_o
);

   localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

   if (CLK_DIV < 1) begin : g_bad_div
      $error("fcs_shifter: CLK_DIV must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("fcs_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sreg;
   logic [BW-1:0]     bits_left;
   logic [DW-1:0]     div_cnt;
   logic              sck_q;
   logic              active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg      <= '0;
         bits_left <= '0;
         div_cnt   <= '0;
         sck_q     <= 1'b0;
         active    <= 1'b0;
      end else if (!active) begin
         if (load_i) begin
            sreg      <= data_i;
            bits_left <= BW'(DATA_W);
            div_cnt   <= '0;
            sck_q     <= 1'b0;
            active    <= 1'b1;
         end
      end else if (div_cnt == DIV_LAST) begin
         div_cnt <= '0;
         if (!sck_q) begin
            sck_q <= 1'b1;
         end else begin
            sck_q     <= 1'b0;
            sreg      <= {sreg[DATA_W-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
            if (bits_left == BW'(1)) active <= 1'b0;
         end
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   assign idle_o = !active;
   assign sck_o  = sck_q;
   assign mosi_o = active & sreg[DATA_W-1];

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq #(
   parameter int CLK_DIV      = 2,
   parameter int HOLD_CYCLES  = 100000,
   parameter int RDY_TIMEOUT  = 1000000,
   parameter int DONE_TIMEOUT = 100000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] byte_data_i,
   input  logic       byte_valid_i,
   input  logic       byte_last_i,
   output logic       byte_ready_o,
   input  logic       rdy_st_i,
   input  logic       done_st_i,
   output logic       prog_o,
   output logic       spi_sck_o,
   output logic       spi_mosi_o,
   output logic       ureset_n_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       err_o,
   output logic [1:0] err_code_o
);
   import fcs_pkg::*;

   localparam int TMAX = fcs_max3(HOLD_CYCLES, RDY_TIMEOUT, DONE_TIMEOUT);
   localparam int TW   = $clog2(TMAX + 1);

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("fpga_cfg_seq: HOLD_CYCLES must be at least 1");
   end
   if (RDY_TIMEOUT < 1 || DONE_TIMEOUT < 1) begin : g_bad_to
      $error("fpga_cfg_seq: timeouts must be at least 1");
   end

   fcs_state_e    st_q, st_n;
   fcs_err_e      err_q, err_n;
   logic          last_q, last_n;
   logic          rdy_s, done_s;
   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic          sh_idle, hs;

   fcs_sync #(.STAGES(SYNC_STAGES)) u_sync_rdy (
      .clk(clk), .rst_n(rst_n), .d_i(rdy_st_i), .q_o(rdy_s));

   fcs_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d_i(done_st_i), .q_o(done_s));

   fcs_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
      .zero_o(tmr_zero));

   assign byte_ready_o = (st_q == ST_XFER) && sh_idle && !last_q;
   assign hs           = byte_ready_o && byte_valid_i;

   fcs_shifter #(.CLK_DIV(CLK_DIV), .DATA_W(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(hs), .data_i(byte_data_i),
      .idle_o(sh_idle), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o));

   always_comb begin
      st_n     = st_q;
      err_n    = err_q;
      last_n   = last_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE, ST_FINISH, ST_ERROR: begin
            if (start_i) begin
               st_n     = ST_WAIT_RDY;
               err_n    = ERR_NONE;
               last_n   = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = TW'(RDY_TIMEOUT);
            end
         end
         ST_WAIT_RDY: begin
            if (rdy_s) begin
               st_n = ST_XFER;
            end else if (tmr_zero) begin
               st_n  = ST_ERROR;
               err_n = ERR_RDY_TO;
            end
         end
         ST_XFER: begin
            if (hs && byte_last_i) last_n = 1'b1;
            if (last_q && sh_idle) begin
               st_n     = ST_CHK_DONE;
               tmr_load = 1'b1;
               tmr_val  = TW'(DONE_TIMEOUT);
            end
         end
         ST_CHK_DONE: begin
            if (done_s) begin
               st_n     = ST_HOLD;
               tmr_load = 1'b1;
               tmr_val  = TW'(HOLD_CYCLES);
            end else if (tmr_zero) begin
               st_n  = ST_ERROR;
               err_n = ERR_DONE_TO;
            end
         end
         ST_HOLD: begin
            if (tmr_zero) st_n = ST_FINISH;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         err_q  <= ERR_NONE;
         last_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         err_q  <= err_n;
         last_q <= last_n;
      end
   end

   assign prog_o     = (st_q == ST_WAIT_RDY) || (st_q == ST_XFER) ||
                       (st_q == ST_CHK_DONE) || (st_q == ST_HOLD) ||
                       (st_q == ST_FINISH);
   assign busy_o     = (st_q == ST_WAIT_RDY) || (st_q == ST_XFER) ||
                       (st_q == ST_CHK_DONE) || (st_q == ST_HOLD);
   assign done_o     = (st_q == ST_FINISH);
   assign ureset_n_o = (st_q == ST_FINISH);
   assign err_o      = (st_q == ST_ERROR);
   assign err_code_o = err_q;

endmodule

// File: rtl/fpga_cfg_seq_chk.sv
module fpga_cfg_seq_chk #(
   parameter int HOLD_CYCLES = 100000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       byte_ready_o,
   input logic       prog_o,
   input logic       spi_sck_o,
   input logic       spi_mosi_o,
   input logic       ureset_n_o,
   input logic       busy_o,
   input logic       done_o,
   input logic       err_o,
   input logic [1:0] err_code_o
);

   localparam int QW = $clog2(HOLD_CYCLES + 1);

   // Clocks since the serial clock was last high, held at HOLD_CYCLES.
   logic [QW-1:0] quiet_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           quiet_cnt <= '0;
      else if (spi_sck_o)                   quiet_cnt <= '0;
      else if (quiet_cnt != QW'(HOLD_CYCLES)) quiet_cnt <= quiet_cnt + 1'b1;
   end

   AST_SCK_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck_o |-> (prog_o && busy_o));                                  // R3
   AST_READY_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready_o |-> (prog_o && busy_o));                               // R3
   AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck_o) |-> $stable(spi_mosi_o));                          // R4
   AST_RESET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !ureset_n_o);                                            // R5
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ureset_n_o) |-> (quiet_cnt == QW'(HOLD_CYCLES)));             // R6
   AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (err_code_o != 2'd0) && !prog_o && !ureset_n_o);          // R7
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !ureset_n_o && !err_o));        // R9
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));                                                // R10

endmodule

bind fpga_cfg_seq fpga_cfg_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_ready_o(byte_ready_o),
   .prog_o(prog_o), .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o),
   .ureset_n_o(ureset_n_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
   .err_code_o(err_code_o));

// File: tb/fpga_cfg_seq_tb.sv
module fpga_cfg_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DIV  = 2;
   localparam int HOLD = 20;
   localparam int RTO  = 60;
   localparam int DTO  = 40;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [7:0] byte_data_i = '0;
   logic byte_valid_i = 1'b0, byte_last_i = 1'b0;
   logic rdy_st_i = 1'b0, done_st_i = 1'b0;
   logic byte_ready_o, prog_o, spi_sck_o, spi_mosi_o, ureset_n_o;
   logic busy_o, done_o, err_o;
   logic [1:0] err_code_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpga_cfg_seq #(.CLK_DIV(DIV), .HOLD_CYCLES(HOLD), .RDY_TIMEOUT(RTO),
                  .DONE_TIMEOUT(DTO), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_data_i(byte_data_i),
      .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
      .byte_ready_o(byte_ready_o), .rdy_st_i(rdy_st_i), .done_st_i(done_st_i),
      .prog_o(prog_o), .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o),
      .ureset_n_o(ureset_n_o), .busy_o(busy_o), .done_o(done_o),
      .err_o(err_o), .err_code_o(err_code_o));

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Serial receiver built from the port pins only.
   logic [7:0] rx [8];
   int   rx_n = 0, bitpos = 0, early_sck = 0, period_bad = 0;
   logic [7:0] rx_sh = '0;
   bit   armed = 1'b0;
   time  last_t = 0;

   always @(posedge spi_sck_o) begin
      if (!armed) early_sck++;
      if (bitpos != 0 && ($time - last_t) != time'(2*DIV*CLK_PERIOD)) period_bad++;
      last_t = $time;
      rx_sh  = {rx_sh[6:0], spi_mosi_o};
      bitpos++;
      if (bitpos == 8) begin
         if (rx_n < 8) rx[rx_n] = rx_sh;
         rx_n++;
         bitpos = 0;
      end
   end

   int both_flags = 0, rst_early = 0;
   always @(negedge clk) begin
      if (done_o && err_o) both_flags++;
      if (ureset_n_o && !done_o) rst_early++;
   end

   function automatic logic [7:0] pat(input int id, input int k);
      if (id == 1) return k[0] ? 8'hFF : 8'h00;
      return 8'((id*53 + k*29 + 7) ^ (k << 4));
   endfunction

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic send(input logic [7:0] d, input bit last);
      @(negedge clk);
      byte_valid_i = 1'b1; byte_data_i = d; byte_last_i = last;
      while (!byte_ready_o) @(negedge clk);
      @(negedge clk);
      byte_valid_i = 1'b0; byte_last_i = 1'b0;
   endtask

   task automatic transfer(input int nb, input int dly, input int id, input bit kick_mid);
      int early_rdy = 0;
      int lim;
      rx_n = 0; bitpos = 0; early_sck = 0; period_bad = 0;
      pulse_start();
      chk(prog_o && busy_o && !done_o && !ureset_n_o && !err_o, "R2 start", prog_o, 1);
      for (int c = 0; c < dly*8; c++) begin
         @(negedge clk);
         if (byte_ready_o) early_rdy++;
      end
      chk(early_sck == 0 && early_rdy == 0, "R3 wait for ready", early_sck + early_rdy, 0);
      rdy_st_i = 1'b1; armed = 1'b1;
      for (int k = 0; k < nb; k++) begin
         send(pat(id, k), k == nb-1);
         if (kick_mid && k == 0) pulse_start();   // R9 start while busy
      end
      lim = 0;
      while (rx_n < nb && lim < 2000) begin @(negedge clk); lim++; end
      chk(rx_n == nb, "R4 byte count", rx_n, nb);
      for (int k = 0; k < nb && k < 8; k++)
         chk(rx[k] == pat(id, k), kick_mid ? "R9 data unchanged" : "R4 data", rx[k], pat(id, k));
      chk(period_bad == 0, "R4 sck period", period_bad, 0);
      repeat (6) @(negedge clk);
      chk(!ureset_n_o && busy_o && prog_o, "R5 reset held", ureset_n_o, 0);
   endtask

   task automatic run_ok(input int nb, input int dly, input int id, input bit kick_mid);
      int cnt = 0;
      transfer(nb, dly, id, kick_mid);
      done_st_i = 1'b1;
      while (!ureset_n_o && cnt < 1000) begin @(negedge clk); cnt++; end
      chk(cnt >= HOLD && cnt <= HOLD + SYNC + 4, "R6 hold-off", cnt, HOLD);
      chk(done_o && !err_o && prog_o && !busy_o && err_code_o == 2'd0, "R6 done", done_o, 1);
      rdy_st_i = 1'b0; done_st_i = 1'b0; armed = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int id = 0;
      repeat (3) @(negedge clk);
      chk(!prog_o && !ureset_n_o && !spi_sck_o && !spi_mosi_o && !byte_ready_o &&
          !busy_o && !done_o && !err_o && err_code_o == 2'd0, "R1 in reset", prog_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!prog_o && !ureset_n_o && !spi_sck_o && !busy_o && !done_o && !err_o,
          "R1 after reset", ureset_n_o, 0);

      for (int nb = 1; nb <= 4; nb++)
         for (int dly = 0; dly <= 2; dly++) begin
            run_ok(nb, dly, id, 1'b0);
            id++;
         end

      // R9: restart from finished state drops the user reset again
      run_ok(3, 1, id, 1'b1); id++;

      // R7: ready never arrives
      rx_n = 0; early_sck = 0;
      pulse_start();
      repeat (RTO + SYNC + 8) @(negedge clk);
      chk(err_o && err_code_o == 2'd1 && !prog_o && !ureset_n_o && !busy_o,
          "R7 ready timeout", err_code_o, 1);
      chk(early_sck == 0, "R7 no clocks", early_sck, 0);

      // R9: restart from the error state, then R8: done never arrives
      transfer(2, 0, id, 1'b0); id++;
      chk(!err_o && err_code_o == 2'd0, "R9 restart from error", err_code_o, 0);
      repeat (DTO + SYNC + 8) @(negedge clk);
      chk(err_o && err_code_o == 2'd2 && !ureset_n_o && !done_o,
          "R8 done timeout", err_code_o, 2);
      rdy_st_i = 1'b0; armed = 1'b0;

      // Full run after the error path
      run_ok(4, 0, id, 1'b0); id++;

      chk(both_flags == 0, "R10 done and err exclusive", both_flags, 0);
      chk(rst_early == 0, "R5 reset released only when done", rst_early, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule